// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block decides, every oscillator period, whether the processor core and the peripheral logic (timers, serial port, interrupt logic) get a clock. Software drives it through one byte-wide power register. The register holds an idle request, a power-down request, two general-purpose flags and a baud-doubling bit. The three reserved bits always read as zero. Idle gates the core clock only. Power-down gates both clock enables, which stands for stopping the oscillator. In power-down the external address-latch and program-strobe outputs are forced low. In idle they are held high. In normal running they pass through from the core.

Idle ends when any enabled interrupt is pending. The hardware then clears the idle bit. Power-down ends when any of the external wake lines goes high. Both clocks then stay off for a fixed settling window, counted by an on-chip delay counter, before they come back and the hardware clears the request bits. A reset pin held high for a minimum number of consecutive oscillator periods clears the whole register and restarts the clocks at once, without the settling window. This works from any state.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After the asynchronous reset the register reads 0x00, both clock enables are 1, and `ale_o`/`psen_o` follow `ale_core_i`/`psen_core_i`.
- R2: A write while the core clock is enabled, with `pcon_addr_i` equal to PCON_ADDR (default 0x87), stores the written byte. Field positions are: bit 7 baud doubling, bits 3 and 2 flags, bit 1 power-down, bit 0 idle. Bits 6:4 always read 0. A write to any other address leaves the register unchanged.
- R3: With the idle bit set and the power-down bit clear, from the cycle after the write `cpu_clk_en_o` is 0, `per_clk_en_o` is 1, and `ale_o` and `psen_o` are both 1.
- R4: In idle, `irq_pend_i` sampled high at a clock edge clears the idle bit at that edge. `cpu_clk_en_o` is then 1, and all other register bits are kept.
- R5: With the power-down bit set, both clock enables and both `ale_o` and `psen_o` are 0. If the idle and power-down bits are written as 1 together, power-down takes priority.
- R6: In power-down, `irq_pend_i` without any wake line high has no effect.
- R7: In power-down, any `wake_irq_i` bit sampled high starts the settling window. Both clock enables stay 0 for exactly SETTLE_CYC further edges, counting the sampling edge, and then rise together. The idle and power-down bits are then cleared and the other bits are kept.
- R8: `rst_pin_i` sampled high on RST_HOLD consecutive edges clears the register to 0x00 at the last of those edges and enables both clocks with no settling delay, even from power-down. A shorter pulse has no effect.
- R9: Writes are ignored while `cpu_clk_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pcon_we_i | input | 1 | Register write strobe |
| pcon_addr_i | input | ADDR_W | Write address |
| pcon_wdata_i | input | 8 | Write data |
| pcon_rdata_o | output | 8 | Current register value |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| wake_irq_i | input | WAKE_W | Enabled external wake lines |
| rst_pin_i | input | 1 | Reset pin, active high |
| ale_core_i | input | 1 | Address-latch strobe from the core |
| psen_core_i | input | 1 | Program strobe from the core |
| cpu_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| ale_o | output | 1 | Address-latch output level |
| psen_o | output | 1 | Program strobe output level |

## Verification
The bench builds the block with its default parameters: a 1536-period settling window, a 24-period reset-pin filter, eight wake lines and register address 0x87. At these values the settling window is short enough to count edge by edge. The bench checks that the clocks come back on exactly the 1536th edge. It also drives reset-pin pulses that stop one edge short of the filter length and pulses that just reach it, so both sides of each boundary are checked at their real sizes.

// File: rtl/pwr_clk_pkg.sv
package pwr_clk_pkg;
  typedef enum logic [1:0] {
    PS_RUN    = 2'd0,
    PS_PDOWN  = 2'd1,
    PS_SETTLE = 2'd2
  } pstate_e;

  localparam int unsigned IDL_B  = 0;
  localparam int unsigned PD_B   = 1;
  localparam logic [7:0]  RSV_MASK = 8'h70;
endpackage

// File: rtl/pcc_reg.sv
module pcc_reg
  import pwr_clk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_idl_i,
  input  logic       clr_pd_i,
  input  logic       soft_clr_i,
  output logic [7:0] pcon_o
);
  logic [7:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q <= '0;
    else if (soft_clr_i) q <= '0;
    else if (wr_en_i)    q <= wdata_i & ~RSV_MASK;
    else begin
      if (clr_idl_i) q[IDL_B] <= 1'b0;
      if (clr_pd_i)  q[PD_B]  <= 1'b0;
    end
  end

  assign pcon_o = q;
endmodule

// File: rtl/pcc_rst_filt.sv
module pcc_rst_filt #(
  parameter int unsigned RST_HOLD = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic pin_rst_o
);
  localparam int unsigned CW = $clog2(RST_HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_HOLD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!pin_i)        cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  // qualified on the RST_HOLD-th consecutive high sample
  assign pin_rst_o = pin_i && (cnt_q == LAST);
endmodule

// File: rtl/pcc_seq.sv
module pcc_seq
  import pwr_clk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1536,
  parameter int unsigned WAKE_W     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              idl_i,
  input  logic              pd_i,
  input  logic              irq_i,
  input  logic [WAKE_W-1:0] wake_i,
  input  logic              pin_rst_i,
  input  logic              ale_i,
  input  logic              psen_i,
  output pstate_e           state_o,
  output logic              cpu_en_o,
  output logic              per_en_o,
  output logic              ale_o,
  output logic              psen_o,
  output logic              clr_idl_o,
  output logic              clr_pd_o
);
  localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  pstate_e       state_q;
  logic [CW-1:0] cnt_q;
  logic          settle_done, clk_off;

  assign settle_done = (state_q == PS_SETTLE) && (cnt_q == LAST) && !pin_rst_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PS_RUN;
      cnt_q   <= '0;
    end else if (pin_rst_i) begin
      state_q <= PS_RUN;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PS_RUN:    if (pd_i) state_q <= PS_PDOWN;
        PS_PDOWN:  if (|wake_i) begin
                     state_q <= PS_SETTLE;
                     cnt_q   <= '0;
                   end
        PS_SETTLE: if (cnt_q == LAST) state_q <= PS_RUN;
                   else               cnt_q   <= cnt_q + 1'b1;
        default:   state_q <= PS_RUN;
      endcase
    end
  end

  assign clk_off   = (state_q != PS_RUN) || pd_i;
  assign cpu_en_o  = !clk_off && !idl_i;
  assign per_en_o  = !clk_off;
  assign ale_o     = clk_off ? 1'b0 : (idl_i ? 1'b1 : ale_i);
  assign psen_o    = clk_off ? 1'b0 : (idl_i ? 1'b1 : psen_i);
  assign clr_pd_o  = settle_done;
  assign clr_idl_o = settle_done ||
                     ((state_q == PS_RUN) && idl_i && !pd_i && irq_i && !pin_rst_i);
  assign state_o   = state_q;
endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
  import pwr_clk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1536,
  parameter int unsigned RST_HOLD   = 24,
  parameter int unsigned WAKE_W     = 8,
  parameter int unsigned ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] PCON_ADDR = ADDR_W'(8'h87)
) (
  input  logic              osc_i,
  input  logic              rst_ni,
  input  logic              pcon_we_i,
  input  logic [ADDR_W-1:0] pcon_addr_i,
  input  logic [7:0]        pcon_wdata_i,
  output logic [7:0]        pcon_rdata_o,
  input  logic              irq_pend_i,
  input  logic [WAKE_W-1:0] wake_irq_i,
  input  logic              rst_pin_i,
  input  logic              ale_core_i,
  input  logic              psen_core_i,
  output logic              cpu_clk_en_o,
  output logic              per_clk_en_o,
  output logic              ale_o,
  output logic              psen_o
);
  logic [7:0] pcon_q;
  logic       pin_rst, wr_en, clr_idl, clr_pd;
  pstate_e    state_q;

  assign wr_en = pcon_we_i && (pcon_addr_i == PCON_ADDR) && cpu_clk_en_o && !pin_rst;

  pcc_rst_filt #(.RST_HOLD(RST_HOLD)) i_rst_filt (
    .clk_i     (osc_i),
    .rst_ni    (rst_ni),
    .pin_i     (rst_pin_i),
    .pin_rst_o (pin_rst)
  );

  pcc_reg i_reg (
    .clk_i      (osc_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wdata_i    (pcon_wdata_i),
    .clr_idl_i  (clr_idl),
    .clr_pd_i   (clr_pd),
    .soft_clr_i (pin_rst),
    .pcon_o     (pcon_q)
  );

  pcc_seq #(.SETTLE_CYC(SETTLE_CYC), .WAKE_W(WAKE_W)) i_seq (
    .clk_i     (osc_i),
    .rst_ni    (rst_ni),
    .idl_i     (pcon_q[IDL_B]),
    .pd_i      (pcon_q[PD_B]),
    .irq_i     (irq_pend_i),
    .wake_i    (wake_irq_i),
    .pin_rst_i (pin_rst),
    .ale_i     (ale_core_i),
    .psen_i    (psen_core_i),
    .state_o   (state_q),
    .cpu_en_o  (cpu_clk_en_o),
    .per_en_o  (per_clk_en_o),
    .ale_o     (ale_o),
    .psen_o    (psen_o),
    .clr_idl_o (clr_idl),
    .clr_pd_o  (clr_pd)
  );

  assign pcon_rdata_o = pcon_q;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk
  import pwr_clk_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1536
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] pcon,
  input logic       cpu_en,
  input logic       per_en,
  input logic       ale,
  input logic       psen,
  input logic       irq,
  input logic       pin_rst,
  input pstate_e    state
);
  int unsigned settle_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 settle_cnt <= 0;
    else if (state == PS_SETTLE) settle_cnt <= settle_cnt + 1;
    else                         settle_cnt <= 0;
  end

  AST_PD_STROBES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_en |-> (!ale && !psen && !cpu_en)); // R5

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_en && !cpu_en) |-> (ale && psen)); // R3

  AST_IDLE_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcon[0] && !pcon[1] && per_en && irq && !pin_rst) |=> (!pcon[0] && cpu_en)); // R4

  AST_SETTLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_SETTLE && !pin_rst && settle_cnt < SETTLE_CYC - 1) |=> !per_en); // R7

  AST_SETTLE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PS_SETTLE && !pin_rst && settle_cnt == SETTLE_CYC - 1) |=> (cpu_en || pcon[0])); // R7

  AST_PIN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_rst |=> (pcon == 8'h00 && cpu_en && per_en)); // R8

  AST_OFF_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_en && !pin_rst) |=> $stable(pcon[7:2])); // R9
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.SETTLE_CYC(SETTLE_CYC)) i_chk (
  .clk_i   (osc_i),
  .rst_ni  (rst_ni),
  .pcon    (pcon_q),
  .cpu_en  (cpu_clk_en_o),
  .per_en  (per_clk_en_o),
  .ale     (ale_o),
  .psen    (psen_o),
  .irq     (irq_pend_i),
  .pin_rst (pin_rst),
  .state   (state_q)
);

// File: tb/test_pwr_clk_ctrl.sv
module test_pwr_clk_ctrl;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned SETTLE     = 1536;
  localparam int unsigned HOLD       = 24;

  logic       osc, rst_n, we, irq, rst_pin, ale_c, psen_c;
  logic [7:0] addr, wdata, rdata, wake;
  logic       cpu_en, per_en, ale, psen;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  pwr_clk_ctrl i_pwr_clk_ctrl (
    .osc_i(osc), .rst_ni(rst_n), .pcon_we_i(we), .pcon_addr_i(addr),
    .pcon_wdata_i(wdata), .pcon_rdata_o(rdata), .irq_pend_i(irq),
    .wake_irq_i(wake), .rst_pin_i(rst_pin), .ale_core_i(ale_c),
    .psen_core_i(psen_c), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .ale_o(ale), .psen_o(psen)
  );

  initial osc = 1'b0;
  always #(CLK_PERIOD/2) osc = ~osc;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [7:0] r,
                         input logic c, input logic p, input logic a, input logic s);
    chk({req, " rdata"}, rdata, r);
    chk({req, " cpu_en"}, cpu_en, c);
    chk({req, " per_en"}, per_en, p);
    chk({req, " ale"}, ale, a);
    chk({req, " psen"}, psen, s);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge osc); we = 1'b1; addr = a; wdata = d;
    @(posedge osc);
    @(negedge osc); we = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) begin @(posedge osc); @(negedge osc); end
  endtask

  task automatic t_reset;
    chk_out("R1 reset", 8'h00, 1, 1, 0, 1);
  endtask

  task automatic t_write;
    wr(8'h87, 8'hF4);
    chk("R2 reserved bits read zero", rdata, 8'h84);
    wr(8'h86, 8'hFF);
    chk("R2 other address ignored", rdata, 8'h84);
    wr(8'h87, 8'h00);
    chk_out("R2 cleared", 8'h00, 1, 1, 0, 1);
  endtask

  task automatic t_idle;
    wr(8'h87, 8'h0D);
    chk_out("R3 idle", 8'h0D, 0, 1, 1, 1);
    wr(8'h87, 8'h00);
    chk("R9 write in idle ignored", rdata, 8'h0D);
    step(3);
    chk("R3 idle held", cpu_en, 0);
    irq = 1'b1; step(1); irq = 1'b0;
    chk_out("R4 idle exit", 8'h0C, 1, 1, 0, 1);
    wr(8'h87, 8'h00);
  endtask

  task automatic settle_check(input string req, input logic [7:0] exp_r);
    int lows = 0;
    bit seen = 0;
    @(posedge osc); @(negedge osc); wake = '0;
    for (int k = 0; k <= int'(SETTLE) + 2 && !seen; k++) begin
      if (cpu_en) seen = 1;
      else begin
        lows++;
        if (per_en) begin n_bad++; $display("FAIL %s per_en early actual=1 expected=0", req); end
        step(1);
      end
    end
    chk({req, " settle length"}, lows, SETTLE);
    chk_out({req, " after wake"}, exp_r, 1, 1, 0, 1);
  endtask

  task automatic t_pdown;
    wr(8'h87, 8'h86);
    chk_out("R5 power-down", 8'h86, 0, 0, 0, 0);
    irq = 1'b1; step(3); irq = 1'b0;
    chk_out("R6 irq ignored in power-down", 8'h86, 0, 0, 0, 0);
    wr(8'h87, 8'h00);
    chk("R9 write in power-down ignored", rdata, 8'h86);
    @(negedge osc); wake = 8'h10;
    settle_check("R7 wake", 8'h84);
    wr(8'h87, 8'h00);
  endtask

  task automatic t_both;
    wr(8'h87, 8'h03);
    chk_out("R5 priority", 8'h03, 0, 0, 0, 0);
    step(2);
    @(negedge osc); wake = 8'h01;
    settle_check("R7 wake both bits", 8'h00);
  endtask

  task automatic t_pin;
    wr(8'h87, 8'h0E);
    step(2);
    @(negedge osc); rst_pin = 1'b1;
    step(HOLD - 1);
    rst_pin = 1'b0;
    chk_out("R8 short pulse ignored", 8'h0E, 0, 0, 0, 0);
    step(2);
    rst_pin = 1'b1;
    step(HOLD - 1);
    chk("R8 not yet reset", rdata, 8'h0E);
    step(1);
    rst_pin = 1'b0;
    chk_out("R8 pin reset from power-down", 8'h00, 1, 1, 0, 1);
  endtask

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0; irq = 1'b0; wake = '0;
    rst_pin = 1'b0; ale_c = 1'b0; psen_c = 1'b1;
    repeat (3) @(negedge osc);
    rst_n = 1'b1;
    @(negedge osc);
    t_reset();
    t_write();
    t_idle();
    t_pdown();
    t_both();
    t_pin();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge osc);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule